// File: doc/BRIEF.md
# I2C Address-Match Slave

This block is the target side of a two-wire serial channel for a small controller. It watches the clock and data lines and finds start and stop conditions by itself. It shifts in the first byte after each start and compares the upper seven bits with a programmable own address. When the address matches, the block acknowledges the byte and raises an interrupt. It then receives or sends 8-bit data bytes through a simple CPU-side register interface. Because the interrupt fires only on an address match or on a stop condition, the local CPU can stay asleep while traffic for other targets passes on the bus.

After every ninth (acknowledge) clock of a byte that belongs to this target, the block pulls SCL low. This stalls the master until the CPU has taken the received byte or loaded the next byte to send, and then releases the hold. The block never creates clock edges of its own. Both lines are open-drain: the block reports only "pull low" enables. The bus wiring outside the block combines them with the master's drive.

Top module: `i2c_wake_slave`

## Requirements
- R1: After reset, neither line is pulled low, the interrupt is low and the wait flag is low.
- R2: When bits 7..1 of the first byte after a start (sent MSB first) equal `ownAddr`, the block holds SDA low through the ninth clock and sets the interrupt.
- R3: On an address mismatch the block does not acknowledge, does not set the interrupt, does not stretch SCL, and ignores all further bits until the next start or stop.
- R4: A stop condition (SDA rising while SCL is high) sets the interrupt.
- R5: After the ninth clock of an accepted byte (address, written data, or read data that the master acknowledged), the block holds SCL low and shows the wait flag until `cpuRelease` is pulsed. It then releases SCL.
- R6: In a write transfer, each data byte is received MSB first. It appears on `rxData` after its eighth clock, and the block acknowledges it on the ninth clock. `rxData` changes at no other time.
- R7: In a read transfer, the byte last written through `cpuTxWe` is sent MSB first, and SDA stays stable while SCL is high.
- R8: When the master does not acknowledge a read byte (SDA high on the ninth clock), the block releases SDA, does not stretch SCL, and waits for the next start or stop.
- R9: A repeated start in the middle of a byte aborts that byte and begins a new address phase.
- R10: The interrupt stays set until `cpuIrqClr` is pulsed. A set event in the same cycle as a clear wins.
- R11: `rwFlag` holds bit 0 of the last matching address byte (1 = read, 0 = write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclPullLow | output | 1 | Pulls SCL low (wait state) when 1 |
| sdaPullLow | output | 1 | Pulls SDA low (acknowledge or data 0) when 1 |
| ownAddr | input | 7 | Own 7-bit slave address |
| cpuTxWe | input | 1 | Writes `cpuTxData` into the transmit register |
| cpuTxData | input | 8 | Next byte to send in a read transfer |
| cpuRelease | input | 1 | One-cycle pulse that ends the wait state |
| cpuIrqClr | input | 1 | One-cycle pulse that clears the interrupt |
| rxData | output | 8 | Last received data byte |
| rwFlag | output | 1 | Direction bit of the last matching address |
| waitFlag | output | 1 | High while the block holds SCL low |
| irq | output | 1 | Interrupt request (address match or stop) |

## Verification
The hardest case to reach from the ports is a master that tries to start the next clock while the block is still holding SCL low. The release must then bring SCL and the first transmit bit out together without disturbing SDA during the high phase. The bench master raises its own SCL drive first, checks that the wired line stays low, and pulses `cpuRelease` while it waits. It measures SDA at the start and at the end of every high phase. A repeated start is also issued three bits into a data byte, to show that the address phase restarts cleanly.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = DATA_W - 1;
  localparam int CNT_W  = $clog2(DATA_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_CHK,
    ST_ACK,
    ST_WAIT,
    ST_WR,
    ST_WR_END,
    ST_RD,
    ST_RD_ACK,
    ST_RD_ACKED,
    ST_IGNORE
  } slvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic clrBits;
    logic loadTx;
    logic shiftTx;
    logic latchRx;
    logic setIrq;
    logic sampleRw;
  } ctlStrobe_t;

  // bus events and datapath status seen by control
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
    logic sclHigh;
    logic sdaBit;
    logic bitsDone;
    logic addrMatch;
    logic rwBit;
    logic txMsb;
  } busEvent_t;
endpackage

// File: rtl/i2cw_datapath.sv
module i2cw_datapath
  import i2cw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              cpuTxWe,
  input  logic [DATA_W-1:0] cpuTxData,
  input  logic              cpuIrqClr,
  input  ctlStrobe_t        strb,
  output busEvent_t         evt,
  output logic [DATA_W-1:0] rxData,
  output logic              rwFlag,
  output logic              irq
);
  localparam int LINES = 2;

  logic [LINES-1:0] lineRaw;
  logic [LINES-1:0] lineSync;
  assign lineRaw = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] stages;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stages <= '1;
      else       stages <= {stages[SYNC_STAGES-2:0], lineRaw[g]};
    end
    assign lineSync[g] = stages[SYNC_STAGES-1];
  end

  logic sclS, sdaS, sclD, sdaD;
  assign sclS = lineSync[1];
  assign sdaS = lineSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] txShift;
  logic [CNT_W-1:0]  bitCnt;

  assign evt.startEv   = sclS & sclD & sdaD & ~sdaS;
  assign evt.stopEv    = sclS & sclD & ~sdaD & sdaS;
  assign evt.sclRise   = sclS & ~sclD;
  assign evt.sclFall   = ~sclS & sclD;
  assign evt.sclHigh   = sclS;
  assign evt.sdaBit    = sdaS;
  assign evt.bitsDone  = (bitCnt == CNT_W'(DATA_W - 1));
  assign evt.addrMatch = (shiftReg[DATA_W-1:1] == ownAddr);
  assign evt.rwBit     = shiftReg[0];
  assign evt.txMsb     = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      txShift  <= '1;
    end else begin
      if (strb.shiftIn) shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
      if (strb.loadTx)       txShift <= txReg;
      else if (strb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b1};
      if (strb.clrBits)                       bitCnt <= '0;
      else if (strb.shiftIn || strb.shiftTx)  bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '1;
      rxData <= '0;
      rwFlag <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (cpuTxWe)       txReg  <= cpuTxData;
      if (strb.latchRx)  rxData <= shiftReg;
      if (strb.sampleRw) rwFlag <= shiftReg[0];
      if (strb.setIrq)   irq <= 1'b1;
      else if (cpuIrqClr) irq <= 1'b0;
    end
  end

  // R6
  rx_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> $past(strb.latchRx));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(strb.setIrq));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !cpuIrqClr) |=> irq);
endmodule

// File: rtl/i2cw_control.sv
module i2cw_control
  import i2cw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEvent_t  evt,
  input  logic       cpuRelease,
  output ctlStrobe_t strb,
  output logic       sclPullLow,
  output logic       sdaPullLow,
  output logic       waitFlag
);
  slvState_t curState, nxtState;
  logic sdaAck, ackNxt;
  logic readMode, readNxt;

  always_comb begin
    nxtState = curState;
    strb     = '0;
    ackNxt   = sdaAck;
    readNxt  = readMode;
    if (evt.stopEv) begin
      nxtState    = ST_IDLE;
      ackNxt      = 1'b0;
      strb.setIrq = 1'b1;
    end else if (evt.startEv) begin
      nxtState     = ST_ADDR;
      ackNxt       = 1'b0;
      strb.clrBits = 1'b1;
    end else begin
      case (curState)
        ST_ADDR: if (evt.sclRise) begin
          strb.shiftIn = 1'b1;
          if (evt.bitsDone) nxtState = ST_ADDR_CHK;
        end
        ST_ADDR_CHK: if (evt.sclFall) begin
          if (evt.addrMatch) begin
            ackNxt        = 1'b1;
            strb.setIrq   = 1'b1;
            strb.sampleRw = 1'b1;
            readNxt       = evt.rwBit;
            nxtState      = ST_ACK;
          end else begin
            nxtState = ST_IGNORE;
          end
        end
        ST_ACK: if (evt.sclFall) begin
          ackNxt   = 1'b0;
          nxtState = ST_WAIT;
        end
        ST_WAIT: if (cpuRelease) begin
          strb.clrBits = 1'b1;
          if (readMode) begin
            strb.loadTx = 1'b1;
            nxtState    = ST_RD;
          end else begin
            nxtState = ST_WR;
          end
        end
        ST_WR: if (evt.sclRise) begin
          strb.shiftIn = 1'b1;
          if (evt.bitsDone) nxtState = ST_WR_END;
        end
        ST_WR_END: if (evt.sclFall) begin
          strb.latchRx = 1'b1;
          ackNxt       = 1'b1;
          nxtState     = ST_ACK;
        end
        ST_RD: if (evt.sclFall) begin
          if (evt.bitsDone) nxtState = ST_RD_ACK;
          else              strb.shiftTx = 1'b1;
        end
        ST_RD_ACK: if (evt.sclRise) begin
          nxtState = evt.sdaBit ? ST_IGNORE : ST_RD_ACKED;
        end
        ST_RD_ACKED: if (evt.sclFall) nxtState = ST_WAIT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_IDLE;
      sdaAck   <= 1'b0;
      readMode <= 1'b0;
    end else begin
      curState <= nxtState;
      sdaAck   <= ackNxt;
      readMode <= readNxt;
    end
  end

  assign waitFlag   = (curState == ST_WAIT);
  assign sclPullLow = waitFlag;
  assign sdaPullLow = sdaAck | ((curState == ST_RD) & ~evt.txMsb);

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitFlag && !cpuRelease) |=> waitFlag);

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IGNORE) |-> (!sdaPullLow && !sclPullLow));

  // R7
  rd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_RD && evt.sclHigh) |=>
      (!evt.sclHigh || curState != ST_RD || $stable(sdaPullLow)));

  // R2
  ack_after_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_ADDR_CHK && evt.sclFall && evt.addrMatch &&
     !evt.startEv && !evt.stopEv) |=> sdaPullLow);
endmodule

// File: rtl/i2c_wake_slave.sv
module i2c_wake_slave
  import i2cw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              cpuTxWe,
  input  logic [DATA_W-1:0] cpuTxData,
  input  logic              cpuRelease,
  input  logic              cpuIrqClr,
  output logic [DATA_W-1:0] rxData,
  output logic              rwFlag,
  output logic              waitFlag,
  output logic              irq
);
  ctlStrobe_t strb;
  busEvent_t  evt;

  i2cw_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ownAddr   (ownAddr),
    .cpuTxWe   (cpuTxWe),
    .cpuTxData (cpuTxData),
    .cpuIrqClr (cpuIrqClr),
    .strb      (strb),
    .evt       (evt),
    .rxData    (rxData),
    .rwFlag    (rwFlag),
    .irq       (irq)
  );

  i2cw_control ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .cpuRelease (cpuRelease),
    .strb       (strb),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow),
    .waitFlag   (waitFlag)
  );
endmodule

// File: tb/i2c_wake_slave_tb_top.sv
module i2c_wake_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int WDOG       = 100000;
  localparam logic [6:0] MY_ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclLine, sdaLine;
  logic sclPullLow, sdaPullLow;
  logic cpuTxWe = 1'b0, cpuRelease = 1'b0, cpuIrqClr = 1'b0;
  logic [7:0] cpuTxData = '0;
  logic [7:0] rxData;
  logic rwFlag, waitFlag, irq;

  int vectors = 0;
  int misses  = 0;
  int glitches = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sclLine = mScl & ~sclPullLow;
  assign sdaLine = mSda & ~sdaPullLow;

  i2c_wake_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow), .ownAddr(MY_ADDR),
    .cpuTxWe(cpuTxWe), .cpuTxData(cpuTxData), .cpuRelease(cpuRelease),
    .cpuIrqClr(cpuIrqClr), .rxData(rxData), .rwFlag(rwFlag),
    .waitFlag(waitFlag), .irq(irq)
  );

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulseRelease();
    cpuRelease = 1'b1; @(negedge clk); cpuRelease = 1'b0;
  endtask

  task automatic clearIrq();
    cpuIrqClr = 1'b1; @(negedge clk); cpuIrqClr = 1'b0;
  endtask

  task automatic loadTx(input logic [7:0] d);
    cpuTxData = d; cpuTxWe = 1'b1; @(negedge clk); cpuTxWe = 1'b0;
  endtask

  task automatic clockBit(input logic b, input bit rel, output logic smp, output bit stretched);
    logic a, e;
    stretched = 0;
    mSda = b;
    hold(HALF);
    mScl = 1'b1;
    if (rel) begin
      hold(6);
      stretched = !sclLine;
      pulseRelease();
    end
    while (!sclLine) @(negedge clk);
    hold(2);
    a = sdaLine;
    hold(HALF/2);
    smp = sdaLine;
    hold(HALF/2);
    e = sdaLine;
    if (a !== e) glitches++;
    mScl = 1'b0;
    hold(HALF/2);
  endtask

  task automatic writeByte(input logic [7:0] d, input bit rel, output logic ackSmp, output bit stretched);
    logic s; bit st;
    stretched = 0;
    for (int i = 7; i >= 0; i--) begin
      clockBit(d[i], rel && (i == 7), s, st);
      if (i == 7) stretched = st;
    end
    clockBit(1'b1, 0, ackSmp, st);
  endtask

  task automatic readByte(input bit rel, input logic mAck, output logic [7:0] d, output bit stretched);
    logic s; bit st;
    stretched = 0;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, rel && (i == 7), s, st);
      d[i] = s;
      if (i == 7) stretched = st;
    end
    clockBit(mAck, 0, s, st);
  endtask

  task automatic startCond();
    mSda = 1'b1; hold(HALF);
    mScl = 1'b1;
    while (!sclLine) @(negedge clk);
    hold(HALF);
    mSda = 1'b0; hold(HALF);
    mScl = 1'b0; hold(HALF/2);
  endtask

  task automatic stopCond();
    if (waitFlag) pulseRelease();
    mSda = 1'b0; hold(HALF);
    mScl = 1'b1;
    while (!sclLine) @(negedge clk);
    hold(HALF);
    mSda = 1'b1; hold(HALF);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic ack; bit st; logic [7:0] d; logic s;
    hold(5);
    rstN = 1'b1;
    hold(2);
    // R1 reset state
    chk("R1 sclPullLow", sclPullLow, 0);
    chk("R1 sdaPullLow", sdaPullLow, 0);
    chk("R1 irq", irq, 0);
    chk("R1 waitFlag", waitFlag, 0);

    // write transfer to own address
    startCond();
    writeByte({MY_ADDR, 1'b0}, 0, ack, st);
    chk("R2 addr ack", ack, 0);
    chk("R2 irq on match", irq, 1);
    chk("R11 rwFlag write", rwFlag, 0);
    chk("R5 wait after addr", waitFlag, 1);
    chk("R5 scl held", sclPullLow, 1);
    hold(20);
    chk("R10 irq persists", irq, 1);
    clearIrq();
    chk("R10 irq cleared", irq, 0);
    writeByte(8'hA5, 1, ack, st);
    chk("R5 stretch seen", st, 1);
    chk("R6 data ack", ack, 0);
    chk("R6 rxData", rxData, 8'hA5);
    chk("R5 wait after data", waitFlag, 1);
    writeByte(8'h3C, 1, ack, st);
    chk("R6 rxData second", rxData, 8'h3C);
    stopCond();
    chk("R4 irq on stop", irq, 1);
    clearIrq();

    // mismatch
    startCond();
    writeByte(8'h22, 0, ack, st);
    chk("R3 no ack", ack, 1);
    chk("R3 no irq", irq, 0);
    chk("R3 no wait", waitFlag, 0);
    writeByte(8'h00, 0, ack, st);
    chk("R3 data ignored ack", ack, 1);
    chk("R3 rxData kept", rxData, 8'h3C);
    chk("R3 scl free", sclPullLow, 0);
    stopCond();
    chk("R4 irq on stop after mismatch", irq, 1);
    clearIrq();

    // read transfer
    loadTx(8'h96);
    startCond();
    writeByte({MY_ADDR, 1'b1}, 0, ack, st);
    chk("R2 read addr ack", ack, 0);
    chk("R11 rwFlag read", rwFlag, 1);
    chk("R5 wait before read", waitFlag, 1);
    clearIrq();
    readByte(1, 1'b0, d, st);
    chk("R7 read byte", d, 8'h96);
    chk("R5 stretch on read", st, 1);
    chk("R5 wait after master ack", waitFlag, 1);
    loadTx(8'h5B);
    readByte(1, 1'b1, d, st);
    chk("R7 read byte two", d, 8'h5B);
    hold(4);
    chk("R8 no wait after nack", waitFlag, 0);
    chk("R8 scl free", sclPullLow, 0);
    chk("R8 sda released", sdaPullLow, 0);
    stopCond();
    clearIrq();

    // repeated start mid-byte
    startCond();
    writeByte({MY_ADDR, 1'b0}, 0, ack, st);
    chk("R9 first addr ack", ack, 0);
    clearIrq();
    clockBit(1'b1, 1, s, st);
    clockBit(1'b0, 0, s, st);
    clockBit(1'b1, 0, s, st);
    startCond();
    chk("R9 no irq at restart", irq, 0);
    loadTx(8'hC3);
    writeByte({MY_ADDR, 1'b1}, 0, ack, st);
    chk("R9 new addr ack", ack, 0);
    chk("R9 irq on new match", irq, 1);
    chk("R11 rwFlag after restart", rwFlag, 1);
    readByte(1, 1'b1, d, st);
    chk("R9 read after restart", d, 8'hC3);
    stopCond();

    chk("R7 sda stable while scl high", glitches, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule